// File: doc/BRIEF.md
# Byte/Pair Register File with Address Pointers

This block is the working register store of a small 8-bit RISC core. It holds thirty-two 8-bit registers. Two independent combinational byte read ports feed the ALU operands. A third combinational port returns an aligned register pair as a single 16-bit operand. One write port commits either a single byte or a 16-bit result into an aligned pair on the next rising clock edge.

The six highest registers are also presented as three 16-bit address pointers, P0, P1 and P2, which are always visible on outputs. The load/store unit uses them for indirect addressing. The whole file can also be reached through a data-space port at addresses 0x00 to 0x1F. This lets the load/store unit read and store registers like memory, including through a pointer that aims back into the file.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to 0x00 at the clock edge where it is sampled.
- R2: Read ports A and B are combinational and independent: each returns the register its 5-bit select names. A write made in the same cycle becomes visible only after the edge, so a same-cycle read returns the old contents.
- R3: With `wr_en` high and `wr_wide` low, `wr_data[7:0]` is written into the register named by `wr_sel` at the next rising edge.
- R4: With `wr_en` and `wr_wide` both high and `wr_sel` even, `wr_data[7:0]` goes to register `wr_sel` and `wr_data[15:8]` to register `wr_sel+1` on the same edge. With an odd `wr_sel`, a wide write changes no register.
- R5: `pair_data` equals {R[2k+1], R[2k]}, where k is `pair_sel[4:1]`. Bit 0 of `pair_sel` is ignored.
- R6: `ptr_p0` = {R27,R26}, `ptr_p1` = {R29,R28} and `ptr_p2` = {R31,R30}: the lower-numbered register is the low byte. All three are combinational.
- R7: For a 16-bit `ds_addr` below 0x20, `ds_hit` is 1 and `ds_rdata` is register `ds_addr`. At any other address, `ds_hit` is 0 and `ds_rdata` is 0x00.
- R8: A store with `ds_we` high and `ds_addr` below 0x20 writes `ds_wdata` into register `ds_addr` at the next edge. A store to 0x20 or above changes no register.
- R9: When a core write (byte or either half of a pair) and a data-space store target the same register in one cycle, the core value is kept. When they target different registers, both commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Contents of the register selected on port A |
| rd_b_sel | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Contents of the register selected on port B |
| pair_sel | input | 5 | Pair index for the 16-bit read; bit 0 is ignored |
| pair_data | output | 16 | Selected register pair, high register in the upper byte |
| wr_en | input | 1 | Core write enable |
| wr_wide | input | 1 | 1 = 16-bit pair write, 0 = byte write |
| wr_sel | input | 5 | Destination register (even for pair writes) |
| wr_data | input | 16 | Write data; the upper byte is used only by pair writes |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space store enable |
| ds_wdata | input | 8 | Data-space store byte |
| ds_rdata | output | 8 | Data-space load byte, 0x00 outside the file |
| ds_hit | output | 1 | Data-space address falls inside the register file |
| ptr_p0 | output | 16 | Pointer formed from registers 27:26 |
| ptr_p1 | output | 16 | Pointer formed from registers 29:28 |
| ptr_p2 | output | 16 | Pointer formed from registers 31:30 |

## Verification
The bench first reads a register during the same cycle that a write hits it. A design with forwarding or a level-sensitive store would return the new byte one cycle early. Wide writes to every odd index are checked to leave every register untouched, because a design that drops bit 0 would silently overwrite a neighbouring pair. Stores at 0x20, 0x100 and 0xFFFF are checked to leave the file unchanged, which catches address decoders that look only at the low five bits. Collisions between a core write and a data-space store on the same register, including the high half of a pair, are checked to keep the core value, and collisions on different registers are checked to commit both values. The three pointers are compared after every write, so a swapped high and low byte or a wrong base register shows at once.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int unsigned GPR_COUNT = 32;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned IDX_W     = $clog2(GPR_COUNT);
    localparam int unsigned DSA_W     = 16;
    localparam int unsigned PTR_BASE  = 26;
    localparam int unsigned PTR_COUNT = 3;
    localparam int unsigned WORD_W    = 2 * DATA_W;

    typedef logic [DATA_W-1:0]                   byte_t;
    typedef logic [WORD_W-1:0]                   word_t;
    typedef logic [IDX_W-1:0]                    idx_t;
    typedef logic [DSA_W-1:0]                    dsa_t;
    typedef logic [GPR_COUNT-1:0][DATA_W-1:0]    file_t;
    typedef logic [PTR_COUNT-1:0][WORD_W-1:0]    ptrs_t;

    typedef enum logic {
        WR_BYTE = 1'b0,
        WR_PAIR = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic     valid;
        wr_kind_e kind;
        idx_t     idx;
        word_t    data;
    } core_wr_t;

    typedef struct packed {
        logic  valid;
        dsa_t  addr;
        byte_t data;
    } ds_wr_t;

    // True when a data-space address lands inside the register file.
    function automatic logic ds_in_file(dsa_t a);
        return a < dsa_t'(GPR_COUNT);
    endfunction

    // Pair writes are legal only on even indices.
    function automatic logic pair_aligned(idx_t i);
        return ~i[0];
    endfunction

endpackage

// File: rtl/gpr_wr_ctrl.sv
module gpr_wr_ctrl
    import gpr_pkg::*;
(
    input  core_wr_t               core_req,
    input  ds_wr_t                 ds_req,
    output logic [GPR_COUNT-1:0]   reg_en,
    output file_t                  reg_nxt
);

    for (genvar g = 0; g < GPR_COUNT; g++) begin : g_slot
        localparam idx_t ME = idx_t'(g);
        logic lo_hit;
        logic hi_hit;
        logic ds_hit;

        always_comb begin
            lo_hit = core_req.valid && (core_req.idx == ME) &&
                     ((core_req.kind == WR_BYTE) || pair_aligned(core_req.idx));
            hi_hit = core_req.valid && (core_req.kind == WR_PAIR) &&
                     pair_aligned(core_req.idx) && ME[0] &&
                     (core_req.idx[IDX_W-1:1] == ME[IDX_W-1:1]);
            ds_hit = ds_req.valid && ds_in_file(ds_req.addr) &&
                     (ds_req.addr[IDX_W-1:0] == ME);

            reg_en[g] = lo_hit || hi_hit || ds_hit;
            // Core port outranks the data-space port.
            if (lo_hit)
                reg_nxt[g] = core_req.data[DATA_W-1:0];
            else if (hi_hit)
                reg_nxt[g] = core_req.data[WORD_W-1:DATA_W];
            else
                reg_nxt[g] = ds_req.data;
        end
    end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GPR_COUNT-1:0] reg_en,
    input  file_t                reg_nxt,
    output file_t                file_q
);

    for (genvar g = 0; g < GPR_COUNT; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                file_q[g] <= '0;
            else if (reg_en[g])
                file_q[g] <= reg_nxt[g];
        end
    end

endmodule

// File: rtl/gpr_byte_mux.sv
module gpr_byte_mux
    import gpr_pkg::*;
(
    input  file_t file_q,
    input  idx_t  sel,
    output byte_t data
);

    assign data = file_q[sel];

endmodule

// File: rtl/gpr_ptrs.sv
module gpr_ptrs
    import gpr_pkg::*;
(
    input  file_t file_q,
    output ptrs_t ptrs
);

    for (genvar p = 0; p < PTR_COUNT; p++) begin : g_ptr
        localparam int unsigned LO = PTR_BASE + 2 * p;
        assign ptrs[p] = {file_q[LO + 1], file_q[LO]};
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_a_sel,
    output logic [7:0]  rd_a_data,
    input  logic [4:0]  rd_b_sel,
    output logic [7:0]  rd_b_data,
    input  logic [4:0]  pair_sel,
    output logic [15:0] pair_data,
    input  logic        wr_en,
    input  logic        wr_wide,
    input  logic [4:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [15:0] ds_addr,
    input  logic        ds_we,
    input  logic [7:0]  ds_wdata,
    output logic [7:0]  ds_rdata,
    output logic        ds_hit,
    output logic [15:0] ptr_p0,
    output logic [15:0] ptr_p1,
    output logic [15:0] ptr_p2
);

    file_t                file_q;
    file_t                reg_nxt;
    logic [GPR_COUNT-1:0] reg_en;
    core_wr_t             core_req;
    ds_wr_t               ds_req;
    ptrs_t                ptrs;
    byte_t                pair_lo;
    byte_t                pair_hi;
    byte_t                ds_byte;

    always_comb begin
        core_req.valid = wr_en;
        core_req.kind  = wr_wide ? WR_PAIR : WR_BYTE;
        core_req.idx   = wr_sel;
        core_req.data  = wr_data;
        ds_req.valid   = ds_we;
        ds_req.addr    = ds_addr;
        ds_req.data    = ds_wdata;
    end

    gpr_wr_ctrl u_wr (
        .core_req (core_req),
        .ds_req   (ds_req),
        .reg_en   (reg_en),
        .reg_nxt  (reg_nxt)
    );

    gpr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .reg_en  (reg_en),
        .reg_nxt (reg_nxt),
        .file_q  (file_q)
    );

    gpr_byte_mux u_rd_a  (.file_q(file_q), .sel(rd_a_sel),                  .data(rd_a_data));
    gpr_byte_mux u_rd_b  (.file_q(file_q), .sel(rd_b_sel),                  .data(rd_b_data));
    gpr_byte_mux u_pr_lo (.file_q(file_q), .sel({pair_sel[4:1], 1'b0}),     .data(pair_lo));
    gpr_byte_mux u_pr_hi (.file_q(file_q), .sel({pair_sel[4:1], 1'b1}),     .data(pair_hi));
    gpr_byte_mux u_ds    (.file_q(file_q), .sel(ds_addr[IDX_W-1:0]),        .data(ds_byte));

    assign pair_data = {pair_hi, pair_lo};
    assign ds_hit    = ds_in_file(ds_addr);
    assign ds_rdata  = ds_hit ? ds_byte : '0;

    gpr_ptrs u_ptrs (
        .file_q (file_q),
        .ptrs   (ptrs)
    );

    assign ptr_p0 = ptrs[0];
    assign ptr_p1 = ptrs[1];
    assign ptr_p2 = ptrs[2];

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
    import gpr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_wide,
    input logic [4:0]  wr_sel,
    input logic [15:0] wr_data,
    input logic [15:0] ds_addr,
    input logic        ds_we,
    input logic [7:0]  ds_wdata,
    input file_t       file_q
);

    logic        seen_q;
    logic        c_en_q, c_wide_q, d_we_q;
    logic [4:0]  c_sel_q;
    logic [15:0] c_data_q, d_addr_q;
    logic [7:0]  d_data_q;
    file_t       prev_q;
    logic        core_on_ds;

    always_ff @(posedge clk) begin
        seen_q   <= !rst;
        c_en_q   <= wr_en;
        c_wide_q <= wr_wide;
        c_sel_q  <= wr_sel;
        c_data_q <= wr_data;
        d_we_q   <= ds_we;
        d_addr_q <= ds_addr;
        d_data_q <= ds_wdata;
        prev_q   <= file_q;
    end

    // Did last cycle's core write cover the data-space target register?
    always_comb begin
        core_on_ds = c_en_q &&
            ((!c_wide_q && c_sel_q == d_addr_q[4:0]) ||
             (c_wide_q && !c_sel_q[0] && c_sel_q[4:1] == d_addr_q[4:1]));
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> file_q == '0);

    assert_byte_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && c_en_q && !c_wide_q) |-> file_q[c_sel_q] == c_data_q[7:0]);

    assert_pair_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && c_en_q && c_wide_q && !c_sel_q[0]) |->
            (file_q[c_sel_q] == c_data_q[7:0] && file_q[c_sel_q | 5'd1] == c_data_q[15:8]));

    assert_odd_pair_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && c_en_q && c_wide_q && c_sel_q[0] && !d_we_q) |-> file_q == prev_q);

    assert_ds_store_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && d_we_q && d_addr_q < 16'h0020 && !core_on_ds) |->
            file_q[d_addr_q[4:0]] == d_data_q);

    assert_ds_high_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && d_we_q && d_addr_q >= 16'h0020 && !c_en_q) |-> file_q == prev_q);

endmodule

bind gpr_file gpr_file_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ds_addr  (ds_addr),
    .ds_we    (ds_we),
    .ds_wdata (ds_wdata),
    .file_q   (file_q)
);

// File: tb/gpr_file_test.sv
module gpr_file_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, pair_sel = '0, wr_sel = '0;
    logic [7:0]  rd_a_data, rd_b_data, ds_rdata, ds_wdata = '0;
    logic [15:0] pair_data, wr_data = '0, ds_addr = '0;
    logic        wr_en = 1'b0, wr_wide = 1'b0, ds_we = 1'b0, ds_hit;
    logic [15:0] ptr_p0, ptr_p1, ptr_p2;

    int tests = 0;
    int fails = 0;
    logic [7:0] ref_q [0:31];

    always #2 clk = ~clk;

    gpr_file uut (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .pair_sel(pair_sel), .pair_data(pair_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_hit(ds_hit),
        .ptr_p0(ptr_p0), .ptr_p1(ptr_p1), .ptr_p2(ptr_p2)
    );

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_ptrs(string ctx);
        chk("R6", {ctx, " P0"}, ptr_p0, {ref_q[27], ref_q[26]});
        chk("R6", {ctx, " P1"}, ptr_p1, {ref_q[29], ref_q[28]});
        chk("R6", {ctx, " P2"}, ptr_p2, {ref_q[31], ref_q[30]});
    endtask

    // Full sweep of every read path against the reference array.
    task automatic sweep(string ctx);
        for (int i = 0; i < 32; i++) begin
            rd_a_sel = 5'(i);
            rd_b_sel = 5'(31 - i);
            pair_sel = 5'(i);
            ds_addr  = 16'(i);
            #1;
            chk("R2", {ctx, " port A"}, {8'h00, rd_a_data}, {8'h00, ref_q[i]});
            chk("R2", {ctx, " port B"}, {8'h00, rd_b_data}, {8'h00, ref_q[31 - i]});
            chk("R5", {ctx, " pair"}, pair_data, {ref_q[i | 1], ref_q[i & 30]});
            chk("R7", {ctx, " ds load"}, {7'h00, ds_hit, ds_rdata}, {7'h00, 1'b1, ref_q[i]});
        end
        chk_ptrs(ctx);
    endtask

    // One clock: model the commit from the requirements, then compare.
    task automatic tick(string ctx);
        logic [7:0] nxt [0:31];
        for (int i = 0; i < 32; i++) nxt[i] = ref_q[i];
        if (ds_we && ds_addr < 16'h0020) nxt[ds_addr[4:0]] = ds_wdata;       // R8
        if (wr_en) begin
            if (!wr_wide) nxt[wr_sel] = wr_data[7:0];                         // R3
            else if (!wr_sel[0]) begin                                        // R4
                nxt[wr_sel]        = wr_data[7:0];
                nxt[wr_sel | 5'd1] = wr_data[15:8];
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 32; i++) ref_q[i] = (rst ? 8'h00 : nxt[i]);
        wr_en = 1'b0;
        wr_wide = 1'b0;
        ds_we = 1'b0;
        chk_ptrs(ctx);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_q[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        sweep("after reset R1");

        // R3 byte writes with a same-cycle read (R2: old value).
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_wide = 1'b0; wr_sel = 5'(i);
            wr_data = {8'hEE, 8'((i * 37 + 11) & 255)};
            rd_a_sel = 5'(i);
            #1;
            chk("R2", "same-cycle read", {8'h00, rd_a_data}, {8'h00, ref_q[i]});
            tick("R3 byte write");
            chk("R3", "byte after edge", {8'h00, rd_a_data}, {8'h00, ref_q[i]});
            chk("R3", "byte value", {8'h00, ref_q[i]}, {8'h00, 8'((i * 37 + 11) & 255)});
        end
        sweep("after byte writes");

        // R4 pair writes to even indices.
        for (int d = 0; d < 32; d += 2) begin
            wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 5'(d);
            wr_data = {8'((d * 5 + 1) & 255), 8'((d * 3 + 200) & 255)};
            tick("R4 pair write");
            pair_sel = 5'(d + 1);
            #1;
            chk("R4", "pair readback", pair_data,
                {8'((d * 5 + 1) & 255), 8'((d * 3 + 200) & 255)});
        end
        sweep("after pair writes");

        // R4 odd wide writes must leave everything unchanged.
        for (int d = 1; d < 32; d += 2) begin
            wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 5'(d); wr_data = 16'hDEAD;
            tick("R4 odd ignored");
        end
        sweep("after odd pair writes R4");

        // R8 data-space stores inside and outside the file.
        for (int a = 0; a < 32; a++) begin
            ds_we = 1'b1; ds_addr = 16'(a); ds_wdata = 8'(a) ^ 8'h5A;
            tick("R8 ds store");
            chk("R8", "ds store value", {8'h00, ref_q[a]}, {8'h00, 8'(a) ^ 8'h5A});
        end
        ds_we = 1'b1; ds_addr = 16'h0020; ds_wdata = 8'hFF; tick("R8 high 0x20");
        ds_we = 1'b1; ds_addr = 16'h0100; ds_wdata = 8'hFF; tick("R8 high 0x100");
        ds_we = 1'b1; ds_addr = 16'hFFFF; ds_wdata = 8'hFF; tick("R8 high 0xFFFF");
        sweep("after ds stores R8");
        ds_addr = 16'h0020; #1;
        chk("R7", "miss 0x20", {7'h00, ds_hit, ds_rdata}, 16'h0000);
        ds_addr = 16'h8001; #1;
        chk("R7", "miss 0x8001", {7'h00, ds_hit, ds_rdata}, 16'h0000);

        // R9 collisions.
        wr_en = 1'b1; wr_sel = 5'd5; wr_data = 16'h0011;
        ds_we = 1'b1; ds_addr = 16'h0005; ds_wdata = 8'h22;
        tick("R9 byte collision");
        chk("R9", "core wins byte", {8'h00, ref_q[5]}, 16'h0011);
        wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 5'd26; wr_data = 16'hA1B2;
        ds_we = 1'b1; ds_addr = 16'h001B; ds_wdata = 8'h33;
        tick("R9 pair-high collision");
        chk("R9", "core wins high half", ptr_p0, 16'hA1B2);
        wr_en = 1'b1; wr_sel = 5'd3; wr_data = 16'h0044;
        ds_we = 1'b1; ds_addr = 16'h0009; ds_wdata = 8'h55;
        tick("R9 disjoint");
        chk("R9", "disjoint core", {8'h00, ref_q[3]}, 16'h0044);
        chk("R9", "disjoint ds", {8'h00, ref_q[9]}, 16'h0055);
        sweep("after collisions R9");

        // R1 reset mid-run.
        rst = 1'b1;
        tick("R1 mid reset");
        rst = 1'b0;
        sweep("after mid reset R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule